// File: doc/BRIEF.md
# Serial GPIO Chain Controller

This block runs an external chain of shift registers so that four pins (serial clock, serial data out, serial data in and a load strobe) stand in for many general purpose lines. Software sets up to 32 ports. Each port carries 1 to 4 bits. The block streams the output level of every bit of every enabled port onto the chain and, in the same pass, captures the bit that returns on the data-in pin.

A pass over the chain is a burst. A burst runs continuously in auto-repeat mode, where bursts are separated by a programmable idle gap. A burst can also be fired once by a request bit that clears itself when that burst has finished.

The register port is a plain single-cycle write strobe with a combinational read mux. It is a control interface with no stream semantics, so it has no valid/ready handshake and never applies back-pressure.

Register map (byte-free word addresses on `reg_addr`):

- 0x00 control: [1:0] bits-per-port minus one, [2] auto-repeat, [3] single-shot request, [6:4] gap select.
- 0x01 clock divider: [11:0].
- 0x02 port enable mask: bit p enables port p.
- 0x10 + b: captured input word for bit index b (read-only).
- 0x20 + p: configuration word of port p.

Top module: `serial_gpio_chain`

## Requirements
- R1: After reset every register reads 0, including all port configuration words and input words, and `sio_clk`, `sio_dout` and `sio_load` are low.
- R2: A burst shifts only enabled ports, in ascending port order, and for each port shifts bit indices 0 up to the value of control[1:0], one bit per serial clock period.
- R3: Disabled ports take no serial periods, and their bits in every input word read 0 after a burst.
- R4: The level shifted for bit b of port p is bit 3*b of the configuration word at address 0x20+p. No other bit of that word affects the output.
- R5: One serial period lasts max(divider, 2) system clocks. Within a period, `sio_clk` is low for the first floor(period/2) clocks and high for the rest.
- R6: After the last bit of a burst, `sio_load` is high for exactly one serial period. `sio_clk` stays low during the load period and during the gap.
- R7: Writing 1 to control[3] starts a burst. With control[2]=0, the bit reads 0 again once that burst's load period ends.
- R8: With control[2]=1, a new burst starts after a gap of 2^control[6:4] serial periods that follows each load period, with no limit on the number of bursts. In this mode control[3] is never cleared by hardware.
- R9: Bit p of the input word at 0x10+b holds the data-in level sampled at the end of the period that shifted bit b of port p. The input words change only when a burst ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| sio_clk | output | 1 | Serial chain clock |
| sio_dout | output | 1 | Serial output data |
| sio_din | input | 1 | Serial input data returning from the chain |
| sio_load | output | 1 | Load strobe after the last bit of a burst |

## Verification
The bench builds the block with 6 ports, 4 bits per port and a 12-bit divider. With 6 ports a burst is at most 24 periods long, so many bursts fit in a short run. The small port count also makes the corner cases easy to reach: only the last port enabled, no port enabled, and sparse masks with gaps between enabled ports. Divider values 0, 1, 2, 3, 4 and 5 cover the clamp to 2 as well as odd and even split points of the serial clock.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_LOAD, ST_GAP} sgc_state_e;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_DIV  = 8'h01;
  localparam logic [7:0] A_EN   = 8'h02;
  localparam logic [7:0] A_IN   = 8'h10;
  localparam logic [7:0] A_CFG  = 8'h20;

  localparam int CTRL_AUTO = 2;
  localparam int CTRL_SS   = 3;
  localparam int CTRL_GAP  = 4;
  localparam int SRC_W     = 3;
  localparam int DATA_W    = 32;
endpackage

// File: rtl/sgc_clkdiv.sv
module sgc_clkdiv #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             sclk_hi
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (div < DIV_W'(2)) ? DIV_W'(2) : div;
  assign tick    = run && (cnt_q >= div_eff - DIV_W'(1));
  assign sclk_hi = run && (cnt_q >= (div_eff >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || restart)  cnt_q <= '0;
    else if (tick)             cnt_q <= '0;
    else                       cnt_q <= cnt_q + DIV_W'(1);
  end

  // periods last at least two clocks, so ticks never come back to back
  assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart) |=> !tick);
endmodule

// File: rtl/sgc_seq.sv
module sgc_seq import sgc_pkg::*; #(
  parameter int NUM_PORTS = 32,
  parameter int MAX_BITS  = 4,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int BIT_W    = $clog2(MAX_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [NUM_PORTS-1:0] en_cfg,
  input  logic [BIT_W-1:0]     wm1_cfg,
  input  logic                 auto_rep,
  input  logic                 ss_req,
  input  logic [2:0]           gap_sel,
  output sgc_state_e           state_q,
  output logic [PORT_W-1:0]    port_q,
  output logic [BIT_W-1:0]     bit_q,
  output logic                 launch,
  output logic                 cap_en,
  output logic                 burst_end,
  output logic                 ss_clear
);
  logic [NUM_PORTS-1:0] en_q;
  logic [BIT_W-1:0]     wm_q;
  logic                 owned_q;
  logic [7:0]           gap_cnt;
  logic                 first_found, next_found;
  logic [PORT_W-1:0]    first_idx, next_idx;
  logic                 gap_last, go_gap, go_idle;

  // lowest enabled port overall, and lowest enabled port above the current one
  always_comb begin
    first_found = 1'b0;
    first_idx   = '0;
    next_found  = 1'b0;
    next_idx    = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (en_cfg[i]) begin
        first_found = 1'b1;
        first_idx   = PORT_W'(i);
      end
      if (en_q[i] && (i > int'(port_q))) begin
        next_found = 1'b1;
        next_idx   = PORT_W'(i);
      end
    end
  end

  assign gap_last = (gap_cnt == ((8'd1 << gap_sel) - 8'd1));
  assign cap_en   = (state_q == ST_SHIFT) && tick;

  always_comb begin
    launch    = 1'b0;
    burst_end = 1'b0;
    ss_clear  = 1'b0;
    go_gap    = 1'b0;
    go_idle   = 1'b0;
    case (state_q)
      ST_IDLE: launch = auto_rep || ss_req;
      ST_LOAD: if (tick) begin
        burst_end = 1'b1;
        ss_clear  = owned_q && !auto_rep;
        if (ss_req && !owned_q) launch = 1'b1;
        else if (auto_rep)      go_gap = 1'b1;
        else                    go_idle = 1'b1;
      end
      ST_GAP: begin
        if (ss_req && !owned_q) launch = 1'b1;
        else if (tick && gap_last) begin
          if (auto_rep) launch = 1'b1;
          else          go_idle = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      en_q    <= '0;
      wm_q    <= '0;
      owned_q <= 1'b0;
      port_q  <= '0;
      bit_q   <= '0;
      gap_cnt <= '0;
    end else if (launch) begin
      en_q    <= en_cfg;
      wm_q    <= wm1_cfg;
      owned_q <= ss_req;
      port_q  <= first_idx;
      bit_q   <= '0;
      gap_cnt <= '0;
      state_q <= first_found ? ST_SHIFT : ST_LOAD;
    end else begin
      case (state_q)
        ST_SHIFT: if (tick) begin
          if (bit_q == wm_q) begin
            bit_q <= '0;
            if (next_found) port_q <= next_idx;
            else            state_q <= ST_LOAD;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        ST_LOAD: begin
          if (go_gap) begin
            state_q <= ST_GAP;
            gap_cnt <= '0;
          end else if (go_idle) begin
            state_q <= ST_IDLE;
          end
        end
        ST_GAP: begin
          if (go_idle)   state_q <= ST_IDLE;
          else if (tick) gap_cnt <= gap_cnt + 8'd1;
        end
        default: ;
      endcase
    end
  end

  assert_bit_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |-> (bit_q <= wm_q));
  assert_port_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |-> en_q[port_q]);
endmodule

// File: rtl/sgc_regs.sv
module sgc_regs import sgc_pkg::*; #(
  parameter int NUM_PORTS = 32,
  parameter int MAX_BITS  = 4,
  parameter int DIV_W     = 12,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int BIT_W    = $clog2(MAX_BITS),
  localparam int CFG_W    = SRC_W * MAX_BITS
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                reg_wr,
  input  logic [7:0]                          reg_addr,
  input  logic [DATA_W-1:0]                   reg_wdata,
  output logic [DATA_W-1:0]                   reg_rdata,
  output logic [BIT_W-1:0]                    wm1,
  output logic                                auto_rep,
  output logic                                ss_req,
  output logic [2:0]                          gap_sel,
  output logic [DIV_W-1:0]                    div,
  output logic [NUM_PORTS-1:0]                en,
  output logic [NUM_PORTS-1:0][MAX_BITS-1:0]  lvl,
  input  logic                                launch,
  input  logic                                cap_en,
  input  logic [PORT_W-1:0]                   cap_port,
  input  logic [BIT_W-1:0]                    cap_bit,
  input  logic                                din,
  input  logic                                burst_end,
  input  logic                                ss_clear
);
  logic [NUM_PORTS-1:0][CFG_W-1:0]    cfg_q;
  logic [MAX_BITS-1:0][NUM_PORTS-1:0] shadow_q, in_q;
  logic                               wr_ctrl;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       cfg_q[p] <= '0;
      else if (reg_wr && (reg_addr == A_CFG + 8'(p)))   cfg_q[p] <= reg_wdata[CFG_W-1:0];
    end
    for (genvar b = 0; b < MAX_BITS; b++) begin : g_bit
      assign lvl[p][b] = cfg_q[p][SRC_W*b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm1      <= '0;
      auto_rep <= 1'b0;
      ss_req   <= 1'b0;
      gap_sel  <= '0;
      div      <= '0;
      en       <= '0;
    end else begin
      if (wr_ctrl) begin
        wm1      <= reg_wdata[BIT_W-1:0];
        auto_rep <= reg_wdata[CTRL_AUTO];
        ss_req   <= reg_wdata[CTRL_SS];
        gap_sel  <= reg_wdata[CTRL_GAP +: 3];
      end else if (ss_clear) begin
        ss_req <= 1'b0;
      end
      if (reg_wr && (reg_addr == A_DIV)) div <= reg_wdata[DIV_W-1:0];
      if (reg_wr && (reg_addr == A_EN))  en  <= reg_wdata[NUM_PORTS-1:0];
    end
  end

  // capture into a shadow, publish whole words only at burst end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      in_q     <= '0;
    end else begin
      if (launch)      shadow_q <= '0;
      else if (cap_en) shadow_q[cap_bit][cap_port] <= din;
      if (burst_end)   in_q <= shadow_q;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) begin
      reg_rdata[BIT_W-1:0]      = wm1;
      reg_rdata[CTRL_AUTO]      = auto_rep;
      reg_rdata[CTRL_SS]        = ss_req;
      reg_rdata[CTRL_GAP +: 3]  = gap_sel;
    end
    if (reg_addr == A_DIV) reg_rdata[DIV_W-1:0]     = div;
    if (reg_addr == A_EN)  reg_rdata[NUM_PORTS-1:0] = en;
    for (int b = 0; b < MAX_BITS; b++)
      if (reg_addr == A_IN + 8'(b)) reg_rdata[NUM_PORTS-1:0] = in_q[b];
    for (int p = 0; p < NUM_PORTS; p++)
      if (reg_addr == A_CFG + 8'(p)) reg_rdata[CFG_W-1:0] = cfg_q[p];
  end

  assert_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(burst_end) |-> $stable(in_q));
  assert_ss_clear_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ss_req) && !$past(wr_ctrl)) |-> $past(ss_clear));
endmodule

// File: rtl/serial_gpio_chain.sv
module serial_gpio_chain import sgc_pkg::*; #(
  parameter int NUM_PORTS = 32,
  parameter int MAX_BITS  = 4,
  parameter int DIV_W     = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sio_clk,
  output logic        sio_dout,
  input  logic        sio_din,
  output logic        sio_load
);
  localparam int PORT_W = $clog2(NUM_PORTS);
  localparam int BIT_W  = $clog2(MAX_BITS);

  logic [BIT_W-1:0]                   wm1;
  logic                               auto_rep, ss_req;
  logic [2:0]                         gap_sel;
  logic [DIV_W-1:0]                   div;
  logic [NUM_PORTS-1:0]               en;
  logic [NUM_PORTS-1:0][MAX_BITS-1:0] lvl;
  sgc_state_e                         state;
  logic [PORT_W-1:0]                  port_q;
  logic [BIT_W-1:0]                   bit_q;
  logic                               launch, cap_en, burst_end, ss_clear;
  logic                               tick, sclk_hi;

  sgc_regs #(.NUM_PORTS(NUM_PORTS), .MAX_BITS(MAX_BITS), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wm1(wm1), .auto_rep(auto_rep),
    .ss_req(ss_req), .gap_sel(gap_sel), .div(div), .en(en), .lvl(lvl),
    .launch(launch), .cap_en(cap_en), .cap_port(port_q), .cap_bit(bit_q),
    .din(sio_din), .burst_end(burst_end), .ss_clear(ss_clear));

  sgc_seq #(.NUM_PORTS(NUM_PORTS), .MAX_BITS(MAX_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en_cfg(en), .wm1_cfg(wm1),
    .auto_rep(auto_rep), .ss_req(ss_req), .gap_sel(gap_sel), .state_q(state),
    .port_q(port_q), .bit_q(bit_q), .launch(launch), .cap_en(cap_en),
    .burst_end(burst_end), .ss_clear(ss_clear));

  sgc_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE), .restart(launch),
    .div(div), .tick(tick), .sclk_hi(sclk_hi));

  assign sio_clk  = (state == ST_SHIFT) && sclk_hi;
  assign sio_dout = (state == ST_SHIFT) ? lvl[port_q][bit_q] : 1'b0;
  assign sio_load = (state == ST_LOAD);

  assert_load_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_load && !tick) |=> sio_load);
  assert_sclk_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sio_load |-> !sio_clk);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sio_clk && !sio_load));
endmodule

// File: tb/serial_gpio_chain_test.sv
module serial_gpio_chain_test;
  localparam int NP = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sio_clk, sio_dout, sio_load;
  logic        sio_din = 1'b0;

  always #4 clk = ~clk;

  serial_gpio_chain #(.NUM_PORTS(NP), .MAX_BITS(4), .DIV_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sio_clk(sio_clk),
    .sio_dout(sio_dout), .sio_din(sio_din), .sio_load(sio_load));

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // chain model: presents input bit k after the k-th falling serial edge
  logic [31:0] pat = '0;
  int fall_cnt = 0;
  int nrec = 0;
  logic [31:0] rec = '0;
  longint last_rise = -1;
  int per_cyc = 0, hi_cyc = 0;
  int nload = 0, lw = 0, lw_run = 0, load_iv = 0;
  longint prev_load = -1;

  always @(negedge sio_clk) begin
    fall_cnt++;
    sio_din = pat[fall_cnt % 32];
    hi_cyc = int'(cyc - last_rise);
  end
  always @(posedge sio_clk) begin
    if (nrec < 32) rec[nrec] = sio_dout;
    nrec++;
    if (last_rise >= 0) per_cyc = int'(cyc - last_rise);
    last_rise = cyc;
  end
  always @(posedge clk) if (sio_load) lw_run++;
  always @(posedge sio_load) begin
    nload++;
    lw_run = 0;
    if (prev_load >= 0) load_iv = int'(cyc - prev_load);
    prev_load = cyc;
  end
  always @(negedge sio_load) begin
    lw = lw_run;
    fall_cnt = 0;
    sio_din = pat[0];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [11:0] cfg_val(input logic [15:0] s, input int p, input logic [1:0] mode);
    case (mode)
      2'd1:    return 12'b110110110110;
      2'd2:    return 12'b001001001001;
      default: return 12'(s * (p + 3)) ^ 12'(s >> p) ^ 12'(p * 73);
    endcase
  endfunction

  task automatic wait_ss_clear(output logic [31:0] got);
    int guard = 0;
    do begin
      rd(8'h00, got);
      guard++;
    end while (got[3] && guard < 5000);
  endtask

  // {mode, mask, width-1, seed, divider}
  localparam logic [37:0] VEC [8] = '{
    {2'd0, 6'b111111, 2'd3, 16'h1234, 12'd2},
    {2'd0, 6'b000001, 2'd0, 16'hBEEF, 12'd3},
    {2'd0, 6'b100000, 2'd1, 16'h0F0F, 12'd0},
    {2'd0, 6'b101010, 2'd2, 16'hC3A5, 12'd4},
    {2'd0, 6'b000000, 2'd1, 16'h5555, 12'd2},
    {2'd0, 6'b010011, 2'd3, 16'hFFFF, 12'd1},
    {2'd1, 6'b111111, 2'd3, 16'h0000, 12'd2},
    {2'd2, 6'b110001, 2'd2, 16'h0000, 12'd5}
  };

  task automatic run_vec(input logic [37:0] v);
    logic [1:0]  mode = v[37:36];
    logic [5:0]  m = v[35:30];
    logic [1:0]  w = v[29:28];
    logic [15:0] s = v[27:12];
    logic [11:0] d = v[11:0];
    logic [11:0] cv [NP];
    logic [NP-1:0] exp_in [4];
    logic [31:0] exp_seq, got;
    int deff, k, nl0;
    deff = (d < 2) ? 2 : int'(d);
    for (int p = 0; p < NP; p++) begin
      cv[p] = cfg_val(s, p, mode);
      wr(8'h20 + 8'(p), {20'd0, cv[p]});
    end
    wr(8'h01, {20'd0, d});
    wr(8'h02, {26'd0, m});
    pat = {s, s ^ 16'h3C5A};
    sio_din = pat[0];
    exp_seq = '0; k = 0;
    for (int b = 0; b < 4; b++) exp_in[b] = '0;
    for (int p = 0; p < NP; p++)
      if (m[p])
        for (int b = 0; b <= int'(w); b++) begin
          exp_seq[k] = cv[p][3*b];
          exp_in[b][p] = pat[k];
          k++;
        end
    nrec = 0; rec = '0; last_rise = -1; per_cyc = 0; hi_cyc = 0; nl0 = nload;
    wr(8'h00, 32'h8 | {30'd0, w});
    wait_ss_clear(got);
    check(nrec == k, "R2", "serial bit count", 64'(nrec), 64'(k));
    check(rec == exp_seq, "R4", "serial output levels in order", 64'(rec), 64'(exp_seq));
    check(got[3] == 1'b0, "R7", "single-shot self clear", 64'(got), 64'(got & ~32'h8));
    check(nload == nl0 + 1, "R6", "one load per burst", 64'(nload), 64'(nl0 + 1));
    check(lw == deff, "R6", "load width in clocks", 64'(lw), 64'(deff));
    if (k >= 2) begin
      check(per_cyc == deff, "R5", "serial period", 64'(per_cyc), 64'(deff));
      check(hi_cyc == deff - deff / 2, "R5", "serial clock high time", 64'(hi_cyc), 64'(deff - deff / 2));
    end
    for (int b = 0; b < 4; b++) begin
      rd(8'h10 + 8'(b), got);
      check(got == {26'd0, exp_in[b]}, "R9", "input word", 64'(got), 64'({26'd0, exp_in[b]}));
      check((got[NP-1:0] & ~m) == '0, "R3", "disabled port input bits", 64'(got[NP-1:0] & ~m), 64'(0));
    end
    check(!sio_clk && !sio_load, "R6", "pins quiet when idle", {62'd0, sio_clk, sio_load}, 64'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] got, acc, w_old;
    int n0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    acc = '0;
    for (int a = 0; a < 3; a++) begin rd(8'(a), got); acc |= got; end
    for (int p = 0; p < NP; p++) begin rd(8'h20 + 8'(p), got); acc |= got; end
    for (int b = 0; b < 4; b++) begin rd(8'h10 + 8'(b), got); acc |= got; end
    check(acc == '0, "R1", "registers after reset", 64'(acc), 64'(0));
    check(!sio_clk && !sio_dout && !sio_load, "R1", "pins after reset",
          {61'd0, sio_clk, sio_dout, sio_load}, 64'(0));

    for (int i = 0; i < 8; i++) run_vec(VEC[i]);

    // R9 input words hold during a burst
    rd(8'h10, w_old);
    wr(8'h02, 32'h3F);
    wr(8'h01, 32'd4);
    pat = 32'hA5F0_3C96;
    sio_din = pat[0];
    wr(8'h00, 32'hB);
    repeat (20) @(negedge clk);
    rd(8'h10, got);
    check(got == w_old, "R9", "input word stable mid-burst", 64'(got), 64'(w_old));
    wait_ss_clear(got);
    rd(8'h10, got);
    acc = '0;
    for (int p = 0; p < NP; p++) acc[p] = pat[4*p];
    check(got == acc, "R9", "input word after burst", 64'(got), 64'(acc));

    // R8 auto-repeat with a 4-period gap
    wr(8'h02, 32'h03);
    wr(8'h01, 32'd2);
    n0 = nload;
    wr(8'h00, 32'h24);
    while (nload < n0 + 3) @(negedge clk);
    check(load_iv == 14, "R8", "burst repeat interval", 64'(load_iv), 64'(14));
    wr(8'h00, 32'h2C);
    n0 = nload;
    while (nload < n0 + 2) @(negedge clk);
    rd(8'h00, got);
    check(got[3] == 1'b1, "R8", "single-shot held under auto-repeat", 64'(got[3]), 64'(1));
    check(nload >= n0 + 2, "R8", "bursts continue", 64'(nload), 64'(n0 + 2));
    wr(8'h00, 32'h0);
    repeat (60) @(negedge clk);
    n0 = nload;
    repeat (60) @(negedge clk);
    check(nload == n0, "R8", "bursts stop with auto-repeat off", 64'(nload), 64'(n0));
    check(!sio_clk, "R6", "serial clock low when stopped", 64'(sio_clk), 64'(0));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule